// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block gathers level-sensitive interrupt request lines from peripherals, one line per peripheral, and merges them into a single processor interrupt output. A per-source enable mask gates each line. Software may bind a source to one of a set of numbered vector slots. Each slot holds an enable bit, a source-channel number and a service-routine address. Lower slot numbers carry higher priority.

Enabled sources that no slot claims still raise the interrupt output. They form one non-vectored class that ranks below every slot and shares a single programmable default address. The interrupt routine reads the vector register and receives either the address of the best active slot or the default address. That read freezes the vector. A write of any value to the same register marks end of service and releases it, so the next vector can be presented. Two status registers expose the raw request lines and the enabled requests.

In the usual channel plan, channel 0 is the watchdog, channel 1 is kept for software interrupts, channels 4 and 5 are the two timers and channel 18 is the converter. The block treats every channel alike.

Top module: `vic_core`

## Requirements
- R1: `irq_o` is high exactly when some request line is high and its enable bit is set, whether or not a slot claims it.
- R2: A read of register 0x00 returns the unmasked request lines, with source n at bit n.
- R3: A read of register 0x01 returns the request lines ANDed with the enable mask, with source n at bit n.
- R4: A read of register 0x03 (vector) returns the address of the lowest-numbered slot whose enable bit is set and whose channel is both requesting and enabled.
- R5: When no slot qualifies, the vector read returns the default address held in register 0x04.
- R6: A source that is enabled and requesting but claimed by no enabled slot raises `irq_o` and leaves the vector read at the default address.
- R7: When two enabled slots name the same channel, the lower-numbered slot's address is returned.
- R8: After a vector read, later vector reads return the same value regardless of request changes until any value is written to register 0x03. The next read after that write reflects the current requests.
- R9: After reset the enable mask, default address, all slot controls and addresses, `reg_rdata` and `irq_o` are zero.
- R10: Register reads take one cycle: `reg_rdata` holds the value in the cycle after `reg_rd`. Register 0x02 (enable), 0x04 (default), 0x10+n (slot n control: bit 5 enable, bits 4:0 channel, other bits zero) and 0x20+n (slot n address) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | SRC_N | Level request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The bench targets cases where priority is easy to get wrong. In the duplicate-channel case, a design that scanned from the top slot would return the higher-numbered slot's address. An enabled source that no slot claims would, in a faulty design, either fail to raise `irq_o` or leak a slot address instead of the default. A slot that names a disabled channel would win in a design that forgot the mask. The freeze-and-release sequence changes requests between reads: a design without the lock would present a new vector mid-service, and one that released late would return a stale vector after the end-of-service write.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DATA_W  = 32;
    localparam int RADDR_W = 6;
    localparam int CH_W    = 5;
    localparam int CH_N    = 1 << CH_W;

    typedef struct packed {
        logic            en;
        logic [CH_W-1:0] ch;
    } slot_ctl_t;

    typedef enum logic [RADDR_W-1:0] {
        REG_RAW = 6'h00,
        REG_MSK = 6'h01,
        REG_ENA = 6'h02,
        REG_VEC = 6'h03,
        REG_DEF = 6'h04
    } reg_id_t;

    localparam logic [RADDR_W-1:0] SLOT_CTL_BASE = 6'h10;
    localparam logic [RADDR_W-1:0] SLOT_ADR_BASE = 6'h20;

    function automatic logic [DATA_W-1:0] ctl_word(slot_ctl_t c);
        return DATA_W'(c);
    endfunction
endpackage

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int SLOT_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_ctl_t         ctl [SLOT_N],
    input  logic [DATA_W-1:0] adr [SLOT_N],
    input  logic [SRC_N-1:0]  act,
    input  logic [DATA_W-1:0] def_addr,
    output logic              hit,
    output logic [DATA_W-1:0] vec_addr
);
    logic [CH_N-1:0]   act_pad;
    logic [SLOT_N-1:0] qual;

    assign act_pad = CH_N'(act);

    for (genvar i = 0; i < SLOT_N; i++) begin : g_qual
        assign qual[i] = ctl[i].en && act_pad[ctl[i].ch];
    end

    always_comb begin
        hit      = 1'b0;
        vec_addr = def_addr;
        for (int i = SLOT_N - 1; i >= 0; i--) begin
            if (qual[i]) begin
                hit      = 1'b1;
                vec_addr = adr[i];
            end
        end
    end

    // R5
    default_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |-> (!hit && vec_addr == def_addr));
endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int SLOT_N = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [RADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [SRC_N-1:0]   req,
    input  logic [DATA_W-1:0]  prio_addr,
    output logic [SRC_N-1:0]   ena_q,
    output logic [DATA_W-1:0]  def_q,
    output slot_ctl_t          ctl_q [SLOT_N],
    output logic [DATA_W-1:0]  adr_q [SLOT_N],
    output logic [DATA_W-1:0]  rdata
);
    logic              lock_q;
    logic [DATA_W-1:0] vec_cur;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_vec, wr_vec;

    assign rd_vec = rd_en && addr == REG_VEC;
    assign wr_vec = wr_en && addr == REG_VEC;

    for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[i] <= '0;
                adr_q[i] <= '0;
            end else begin
                if (wr_en && addr == SLOT_CTL_BASE + RADDR_W'(i))
                    ctl_q[i] <= slot_ctl_t'(wdata[CH_W:0]);
                if (wr_en && addr == SLOT_ADR_BASE + RADDR_W'(i))
                    adr_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            REG_RAW: rd_mux = DATA_W'(req);
            REG_MSK: rd_mux = DATA_W'(req & ena_q);
            REG_ENA: rd_mux = DATA_W'(ena_q);
            REG_VEC: rd_mux = vec_cur;
            REG_DEF: rd_mux = def_q;
            default: begin
                for (int i = 0; i < SLOT_N; i++) begin
                    if (addr == SLOT_CTL_BASE + RADDR_W'(i)) rd_mux = ctl_word(ctl_q[i]);
                    if (addr == SLOT_ADR_BASE + RADDR_W'(i)) rd_mux = adr_q[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q   <= '0;
            def_q   <= '0;
            lock_q  <= 1'b0;
            vec_cur <= '0;
            rdata   <= '0;
        end else begin
            if (wr_en && addr == REG_ENA) ena_q <= wdata[SRC_N-1:0];
            if (wr_en && addr == REG_DEF) def_q <= wdata;
            if (wr_vec)      lock_q <= 1'b0;
            else if (rd_vec) lock_q <= 1'b1;
            if ((!lock_q || wr_vec) && !rd_vec) vec_cur <= prio_addr;
            if (rd_en) rdata <= rd_mux;
        end
    end

    // R8
    vec_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && lock_q && !wr_en) |=> (rdata == $past(vec_cur)));
    // R3
    masked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_MSK) |=> (rdata == DATA_W'($past(req) & $past(ena_q))));
    // R10
    ena_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == REG_ENA) |=> (rdata == DATA_W'($past(ena_q))));
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int SLOT_N = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_N-1:0]   irq_req,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o
);
    logic [SRC_N-1:0]  ena_q;
    logic [DATA_W-1:0] def_q;
    slot_ctl_t         ctl_q [SLOT_N];
    logic [DATA_W-1:0] adr_q [SLOT_N];
    logic              hit;
    logic [DATA_W-1:0] prio_addr;
    logic [SRC_N-1:0]  act;

    assign act   = irq_req & ena_q;
    assign irq_o = |act;

    vic_regs #(.SRC_N(SRC_N), .SLOT_N(SLOT_N)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .req(irq_req), .prio_addr(prio_addr),
        .ena_q(ena_q), .def_q(def_q), .ctl_q(ctl_q), .adr_q(adr_q), .rdata(reg_rdata)
    );

    vic_prio #(.SRC_N(SRC_N), .SLOT_N(SLOT_N)) u_prio (
        .clk(clk), .rst(rst), .ctl(ctl_q), .adr(adr_q), .act(act),
        .def_addr(def_q), .hit(hit), .vec_addr(prio_addr)
    );

    // R1
    hit_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> irq_o);
endmodule

// File: tb/vic_core_test.sv
module vic_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_N = 32;
    localparam int SLOT_N = 16;

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] irq_req = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic        m_en  [SLOT_N];
    logic [4:0]  m_ch  [SLOT_N];
    logic [31:0] m_adr [SLOT_N];
    logic [31:0] m_ena, m_def;

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_core #(.SRC_N(SRC_N), .SLOT_N(SLOT_N)) uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", r, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic set_slot(int s, logic en, logic [4:0] ch, logic [31:0] ad);
        m_en[s] = en; m_ch[s] = ch; m_adr[s] = ad;
        wr(6'h10 + 6'(s), {26'd0, en, ch});
        wr(6'h20 + 6'(s), ad);
    endtask

    task automatic set_ena(logic [31:0] v); m_ena = v; wr(6'h02, v); endtask
    task automatic set_def(logic [31:0] v); m_def = v; wr(6'h04, v); endtask
    task automatic set_req(logic [31:0] v); @(negedge clk); irq_req = v; @(negedge clk); endtask

    function automatic logic [31:0] exp_vec(logic [31:0] rq);
        for (int s = 0; s < SLOT_N; s++)
            if (m_en[s] && rq[m_ch[s]] && m_ena[m_ch[s]]) return m_adr[s];
        return m_def;
    endfunction

    task automatic check_vec(string r);
        logic [31:0] d;
        rd(6'h03, d);
        chk(r, d, exp_vec(irq_req));
        wr(6'h03, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v1;
        void'($urandom(32'd1234));
        for (int s = 0; s < SLOT_N; s++) begin m_en[s] = 0; m_ch[s] = 0; m_adr[s] = 0; end
        m_ena = 0; m_def = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9 reset state
        chk("R9 rdata", reg_rdata, 0);
        chk("R9 irq", {31'd0, irq_o}, 0);
        rd(6'h02, d); chk("R9 ena", d, 0);
        rd(6'h04, d); chk("R9 def", d, 0);
        rd(6'h10, d); chk("R9 slot0 ctl", d, 0);
        rd(6'h2F, d); chk("R9 slot15 adr", d, 0);

        // R10 readback
        set_def(32'hDEF0_0000);
        set_ena(32'h0007_FFFF);
        set_slot(0, 1, 5'd4, 32'h0000_1000);
        set_slot(3, 1, 5'd18, 32'h0000_3000);
        rd(6'h04, d); chk("R10 def", d, 32'hDEF0_0000);
        rd(6'h02, d); chk("R10 ena", d, 32'h0007_FFFF);
        rd(6'h13, d); chk("R10 slot3 ctl", d, 32'h0000_0032);
        rd(6'h23, d); chk("R10 slot3 adr", d, 32'h0000_3000);

        // R2 / R3 status
        set_req(32'hF00C_0010);
        rd(6'h00, d); chk("R2 raw", d, 32'hF00C_0010);
        rd(6'h01, d); chk("R3 masked", d, 32'h0004_0010);

        // R4 priority: slot0 (ch4) beats slot3 (ch18)
        check_vec("R4 slot0 wins");
        set_req(32'h0004_0000);
        check_vec("R4 slot3 only");

        // R6 unclaimed enabled source: irq high, default vector
        set_req(32'h0000_0001);
        chk("R6 irq", {31'd0, irq_o}, 1);
        check_vec("R6 default");
        // R5 nothing active
        set_req(32'h0);
        chk("R1 irq low", {31'd0, irq_o}, 0);
        check_vec("R5 default");
        // slot naming a disabled channel does not win (R4)
        set_slot(1, 1, 5'd25, 32'h0000_2500);
        set_req(32'h0200_0000);
        chk("R1 masked irq low", {31'd0, irq_o}, 0);
        check_vec("R4 masked channel");

        // R7 duplicate channel
        set_slot(6, 1, 5'd9, 32'h0000_6000);
        set_slot(2, 1, 5'd9, 32'h0000_2000);
        set_req(32'h0000_0200);
        check_vec("R7 dup lower wins");

        // R8 freeze and release
        set_req(32'h0004_0000);
        rd(6'h03, v1); chk("R8 first", v1, 32'h0000_3000);
        set_req(32'h0000_0010);
        rd(6'h03, d); chk("R8 frozen", d, 32'h0000_3000);
        wr(6'h03, 32'h1234_5678);
        rd(6'h03, d); chk("R8 released", d, 32'h0000_1000);
        wr(6'h03, 32'h0);

        // randomized
        for (int it = 0; it < 300; it++) begin
            if (it % 25 == 0) begin
                for (int s = 0; s < SLOT_N; s++)
                    set_slot(s, 1'($urandom), 5'($urandom), $urandom);
                set_ena($urandom);
                set_def($urandom);
            end
            set_req($urandom & $urandom);
            chk("R1 rand irq", {31'd0, irq_o}, {31'd0, |(irq_req & m_ena)});
            rd(6'h01, d); chk("R3 rand masked", d, irq_req & m_ena);
            check_vec("R4 rand vec");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule